// File: doc/BRIEF.md
# Filtered Memory Access Performance Counters

This block sits beside a memory controller and watches its stream of accepted accesses. Each access arrives with a valid strobe and four attributes:

- the master that issued it;
- whether it targets the SDRAM array or the controller's own register space;
- whether it is a read or a write;
- how many cycles it waited before service.

Two independent saturating counters tally the accesses that pass their own filters. Each counter has three filter stages:

- an event selector, which picks all accesses, reads only, writes only, or slow accesses only;
- an optional master-ID match;
- an optional target-region match.

Software reaches the block through a simple register port. A write is a single-cycle strobe. A read is a combinational lookup on the address. There are four registers: a configuration word, a select word that holds the master IDs and region codes, and the two counts. Any write that changes the filtering restarts the counts, so a count always covers a single filter setting. Writing to a count address clears that count. Software uses the counts to profile traffic from one master, or to one region, over a window it defines itself.

Top module: `mem_perf_counters`

## Requirements
- R1: After reset, the configuration word (address 0) reads 0x0001_0000, the select word (address 1) reads 0, and both counts (address 2 for counter 1, address 3 for counter 2) read 0.
- R2: The configuration word keeps bits 31, 30, 19:16, 15, 14 and 3:0; bits 29:20 and 13:4 always read as zero. The select word keeps bits 27:16 and 11:0; its other bits always read as zero.
- R3: In the configuration word, the event field sits at bits 3:0 for counter 1 and at bits 19:16 for counter 2. The codes are:
  - 0 counts every access;
  - 1 counts reads (write flag low);
  - 2 counts writes;
  - 3 counts accesses whose wait exceeds LONG_WAIT cycles (a wait equal to LONG_WAIT does not count);
  - any other code counts nothing.
- R4: The master filter enable is bit 15 for counter 1 and bit 31 for counter 2. When it is 0, accesses from every master count. When it is 1, only accesses whose master ID equals the counter's select field count. That field is bits 7:0 for counter 1 and bits 23:16 for counter 2.
- R5: The region filter enable is bit 14 for counter 1 and bit 30 for counter 2. When it is 0, the region code is ignored. When it is 1, the region code works as follows:
  - code 0 counts only SDRAM accesses (region flag low);
  - code 7 counts only register-space accesses (region flag high);
  - any other code counts nothing.
  The region code is bits 11:8 for counter 1 and bits 27:24 for counter 2.
- R6: An access adds one to a counter only when its event, master and region stages all pass. The two counters filter independently of each other.
- R7: A counter never wraps. At all-ones it holds its value, and it never grows by more than one per cycle.
- R8: A write to address 0 or 1 clears both counts at that clock edge. A write to address 2 or 3 clears only that count. A clear takes precedence over an access in the same cycle.
- R9: A cycle with the valid strobe low changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| accValid | input | 1 | Access strobe, one access per high cycle |
| accMaster | input | 8 | Master ID of the access |
| accIsReg | input | 1 | 1 = register space, 0 = SDRAM array |
| accWrite | input | 1 | 1 = write, 0 = read |
| accWait | input | WAIT_W | Cycles the access waited |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |

## Verification
The assertions take for granted the following about the inputs:
- regAddr holds a defined value in every cycle;
- each cycle with accValid high stands for exactly one access, so one cycle can add at most one to a count;
- software leaves the reserved configuration bits at zero.

The stimulus keeps to these by driving every input on the falling edge, and by issuing at most one access per strobe cycle. Only the register-width test writes all-ones to the reserved bits, and that test checks the readback alone.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
  localparam int NUM_CNT = 2;
  localparam int MID_W   = 8;
  localparam int RSEL_W  = 4;
  localparam int EV_W    = 4;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 2;

  localparam logic [REG_W-1:0] CFG_MASK  = 32'hC00F_C00F;
  localparam logic [REG_W-1:0] SEL_MASK  = 32'h0FFF_0FFF;
  localparam logic [REG_W-1:0] CFG_RESET = 32'h0001_0000;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SEL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT1 = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT2 = 2'd3;

  localparam logic [RSEL_W-1:0] RSEL_SDRAM = 4'h0;
  localparam logic [RSEL_W-1:0] RSEL_REGS  = 4'h7;

  typedef enum logic [EV_W-1:0] {
    EV_ALL   = 4'd0,
    EV_READ  = 4'd1,
    EV_WRITE = 4'd2,
    EV_SLOW  = 4'd3
  } evCode_t;

  typedef struct packed {
    logic              mstEn;
    logic              regionEn;
    logic [EV_W-1:0]   evSel;
    logic [MID_W-1:0]  mstId;
    logic [RSEL_W-1:0] regionSel;
  } cntCfg_t;

  typedef struct packed {
    logic [NUM_CNT-1:0] clr;
  } ctrlStrobes_t;
endpackage

// File: rtl/perf_cnt_ctrl.sv
module perf_cnt_ctrl
  import perf_cnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            regWrEn,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [REG_W-1:0]                regWrData,
  output logic [REG_W-1:0]                regRdData,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cntVal,
  output cntCfg_t [NUM_CNT-1:0]           cfg,
  output ctrlStrobes_t                    strobes
);
  logic [REG_W-1:0] cfgWord;
  logic [REG_W-1:0] selWord;

  // The configuration and select words are stored already masked, so the
  // reserved bits can never hold ones.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWord <= CFG_RESET;
      selWord <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_CFG) cfgWord <= regWrData & CFG_MASK;
      if (regAddr == ADDR_SEL) selWord <= regWrData & SEL_MASK;
    end
  end

  // Each counter's fields sit at the same offsets inside its own 16-bit half.
  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      cfg[i].mstEn     = cfgWord[16*i+15];
      cfg[i].regionEn  = cfgWord[16*i+14];
      cfg[i].evSel     = cfgWord[16*i +: EV_W];
      cfg[i].mstId     = selWord[16*i +: MID_W];
      cfg[i].regionSel = selWord[16*i+8 +: RSEL_W];
    end
  end

  // A write to either filter word clears both counts; a write to a count
  // address clears only that count.
  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      strobes.clr[i] = regWrEn &&
                       ((regAddr == ADDR_CFG) || (regAddr == ADDR_SEL) ||
                        (regAddr == ADDR_CNT1 + ADDR_W'(i)));
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CFG:  regRdData = cfgWord;
      ADDR_SEL:  regRdData = selWord;
      ADDR_CNT1: regRdData = REG_W'(cntVal[0]);
      default:   regRdData = REG_W'(cntVal[1]);
    endcase
  end
endmodule

// File: rtl/perf_cnt_datapath.sv
module perf_cnt_datapath
  import perf_cnt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int WAIT_W    = 8,
  parameter int LONG_WAIT = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          accValid,
  input  logic [MID_W-1:0]              accMaster,
  input  logic                          accIsReg,
  input  logic                          accWrite,
  input  logic [WAIT_W-1:0]             accWait,
  input  cntCfg_t [NUM_CNT-1:0]         cfg,
  input  ctrlStrobes_t                  strobes,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVal
);
  localparam logic [WAIT_W-1:0] WAIT_LIMIT = WAIT_W'(LONG_WAIT);
  localparam logic [CNT_W-1:0]  CNT_MAX    = '1;

  logic slowAcc;
  assign slowAcc = accWait > WAIT_LIMIT;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic evPass, mstPass, regionPass, hit;

    always_comb begin
      unique case (cfg[i].evSel)
        EV_ALL:   evPass = 1'b1;
        EV_READ:  evPass = !accWrite;
        EV_WRITE: evPass = accWrite;
        EV_SLOW:  evPass = slowAcc;
        default:  evPass = 1'b0;
      endcase
    end

    assign mstPass = !cfg[i].mstEn || (accMaster == cfg[i].mstId);

    always_comb begin
      if (!cfg[i].regionEn)                       regionPass = 1'b1;
      else if (cfg[i].regionSel == RSEL_SDRAM)    regionPass = !accIsReg;
      else if (cfg[i].regionSel == RSEL_REGS)     regionPass = accIsReg;
      else                                        regionPass = 1'b0;
    end

    assign hit = accValid && evPass && mstPass && regionPass;

    // A clear wins over a same-cycle hit; a full counter holds its value.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          cntVal[i] <= '0;
      else if (strobes.clr[i])            cntVal[i] <= '0;
      else if (hit && cntVal[i] != CNT_MAX) cntVal[i] <= cntVal[i] + 1'b1;
    end
  end
endmodule

// File: rtl/mem_perf_counters.sv
module mem_perf_counters
  import perf_cnt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int WAIT_W    = 8,
  parameter int LONG_WAIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [7:0]        accMaster,
  input  logic              accIsReg,
  input  logic              accWrite,
  input  logic [WAIT_W-1:0] accWait,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData
);
  cntCfg_t [NUM_CNT-1:0]         cfg;
  ctrlStrobes_t                  strobes;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;
  logic [NUM_CNT-1:0]            clrVec;

  assign clrVec = strobes.clr;

  perf_cnt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .cntVal(cntVal), .cfg(cfg), .strobes(strobes)
  );

  perf_cnt_datapath #(.CNT_W(CNT_W), .WAIT_W(WAIT_W), .LONG_WAIT(LONG_WAIT)) u_dp (
    .clk(clk), .rstN(rstN),
    .accValid(accValid), .accMaster(accMaster), .accIsReg(accIsReg),
    .accWrite(accWrite), .accWait(accWait),
    .cfg(cfg), .strobes(strobes), .cntVal(cntVal)
  );
endmodule

// File: rtl/perf_cnt_chk.sv
module perf_cnt_chk #(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  accValid,
  input logic                  regWrEn,
  input logic [1:0]            regAddr,
  input logic [31:0]           regRdData,
  input logic [1:0][CNT_W-1:0] cntVal,
  input logic [1:0]            clrVec
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2: reserved configuration bits read back as zero
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0) |-> ((regRdData & 32'h3FF0_3FF0) == 32'd0));

  // R8: a write to either filter word leaves both counts at zero
  assert_filter_write_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == 2'd0 || regAddr == 2'd1)) |=> (cntVal == '0));

  // R9: with no access and no clear, no count moves
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!accValid && clrVec == 2'b00) |=> $stable(cntVal));

  for (genvar i = 0; i < 2; i++) begin : g_chk
    // R7: a full counter stays full until cleared
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
      (cntVal[i] == CNT_MAX && !clrVec[i]) |=> (cntVal[i] == CNT_MAX));

    // R7: without a clear, a count grows by at most one per cycle
    assert_single_step_R7: assert property (@(posedge clk) disable iff (!rstN)
      !clrVec[i] |=> (cntVal[i] == $past(cntVal[i]) ||
                      cntVal[i] == $past(cntVal[i]) + 1'b1));
  end
endmodule

bind mem_perf_counters perf_cnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .regWrEn(regWrEn),
  .regAddr(regAddr), .regRdData(regRdData), .cntVal(cntVal), .clrVec(clrVec)
);

// File: tb/mem_perf_counters_tb.sv
`timescale 1ns/1ps
module mem_perf_counters_tb;
  localparam int CNT_W     = 8;
  localparam int WAIT_W    = 6;
  localparam int LONG_WAIT = 5;
  localparam logic [7:0] MID_A = 8'h5A;
  localparam logic [7:0] MID_B = 8'hC3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0;
  logic [7:0] accMaster = '0;
  logic accIsReg = 1'b0;
  logic accWrite = 1'b0;
  logic [WAIT_W-1:0] accWait = '0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  mem_perf_counters #(.CNT_W(CNT_W), .WAIT_W(WAIT_W), .LONG_WAIT(LONG_WAIT)) u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accMaster(accMaster),
    .accIsReg(accIsReg), .accWrite(accWrite), .accWait(accWait),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic access(input logic [7:0] m, input bit isReg, input bit wr, input int wt);
    @(negedge clk);
    accValid = 1'b1; accMaster = m; accIsReg = isReg; accWrite = wr;
    accWait = WAIT_W'(wt);
    @(negedge clk);
    accValid = 1'b0;
  endtask

  function automatic logic [31:0] cfgWord(input logic [3:0] ev1, input bit m1, input bit r1,
                                          input logic [3:0] ev2, input bit m2, input bit r2);
    return {m2, r2, 10'd0, ev2, m1, r1, 10'd0, ev1};
  endfunction

  function automatic logic [31:0] selWord(input logic [7:0] id1, input logic [3:0] rs1,
                                          input logic [7:0] id2, input logic [3:0] rs2);
    return {4'd0, rs2, id2, 4'd0, rs1, id1};
  endfunction

  // Expected filter outcome, taken from the requirement text
  function automatic bit expHit(input logic [3:0] ev, input bit mEn, input bit rEn,
                                input logic [3:0] rs, input logic [7:0] id,
                                input logic [7:0] m, input bit isReg, input bit wr, input int wt);
    bit e, mp, rp;
    e  = (ev == 0) || (ev == 1 && !wr) || (ev == 2 && wr) || (ev == 3 && wt > LONG_WAIT);
    mp = !mEn || (m == id);
    rp = !rEn || (rs == 4'h0 && !isReg) || (rs == 4'h7 && isReg);
    return e && mp && rp;
  endfunction

  function automatic logic [7:0] pickMaster(input int k);
    case (k)
      0: return MID_A;
      1: return MID_B;
      2: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [3:0] evList [6] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd15};
    logic [3:0] rsList [3] = '{4'h0, 4'h7, 4'h3};

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset values
    readReg(2'd0, rd); check("R1 config", rd, 32'h0001_0000);
    readReg(2'd1, rd); check("R1 select", rd, 32'h0);
    readReg(2'd2, rd); check("R1 count1", rd, 32'h0);
    readReg(2'd3, rd); check("R1 count2", rd, 32'h0);

    // R2 reserved bits
    writeReg(2'd0, 32'hFFFF_FFFF);
    readReg(2'd0, rd); check("R2 config mask", rd, 32'hC00F_C00F);
    writeReg(2'd1, 32'hFFFF_FFFF);
    readReg(2'd1, rd); check("R2 select mask", rd, 32'h0FFF_0FFF);

    // R3 slow-access threshold boundary, counter 1 code 3, counter 2 code 0
    writeReg(2'd0, cfgWord(4'd3, 0, 0, 4'd0, 0, 0));
    access(MID_A, 0, 0, LONG_WAIT);
    access(MID_A, 0, 1, LONG_WAIT + 1);
    readReg(2'd2, rd); check("R3 slow count", rd, 32'd1);
    readReg(2'd3, rd); check("R3 all count", rd, 32'd2);

    // R9 invalid cycles do not count
    @(negedge clk);
    accValid = 1'b0; accMaster = MID_A; accWrite = 1'b1; accWait = '1;
    repeat (10) @(negedge clk);
    readReg(2'd2, rd); check("R9 idle count1", rd, 32'd1);
    readReg(2'd3, rd); check("R9 idle count2", rd, 32'd2);

    // R8 per-counter clear wins over a same-cycle access
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd2; regWrData = '0;
    accValid = 1'b1; accMaster = MID_A; accIsReg = 0; accWrite = 1; accWait = WAIT_W'(LONG_WAIT + 1);
    @(negedge clk);
    regWrEn = 1'b0; accValid = 1'b0;
    readReg(2'd2, rd); check("R8 clear count1", rd, 32'd0);
    readReg(2'd3, rd); check("R8 other count kept", rd, 32'd3);
    writeReg(2'd1, selWord(MID_A, 4'h0, MID_B, 4'h0));
    readReg(2'd3, rd); check("R8 select write clears", rd, 32'd0);

    // R7 saturation at all-ones
    writeReg(2'd0, cfgWord(4'd0, 0, 0, 4'd2, 0, 0));
    for (int n = 0; n < 300; n++) access(8'h11, n[0], 1'b1, 0);
    readReg(2'd2, rd); check("R7 saturate count1", rd, 32'd255);
    readReg(2'd3, rd); check("R7 saturate count2", rd, 32'd255);

    // R3 R4 R5 R6 sweep over filter settings
    writeReg(2'd1, selWord(MID_A, 4'h0, MID_B, 4'h0));
    for (int idx = 0; idx < 72; idx++) begin
      int j;
      int exp1, exp2;
      logic [3:0] e1, e2, s1, s2;
      bit m1, m2, r1, r2;
      j  = 71 - idx;
      e1 = evList[idx % 6];      e2 = evList[j % 6];
      m1 = ((idx / 6) % 2) == 1; m2 = ((j / 6) % 2) == 1;
      r1 = ((idx / 12) % 2) == 1; r2 = ((j / 12) % 2) == 1;
      s1 = rsList[(idx / 24) % 3]; s2 = rsList[(j / 24) % 3];
      writeReg(2'd1, selWord(MID_A, s1, MID_B, s2));
      writeReg(2'd0, cfgWord(e1, m1, r1, e2, m2, r2));
      exp1 = 0; exp2 = 0;
      for (int a = 0; a < 32; a++) begin
        logic [7:0] m;
        bit isReg, wr;
        int wt;
        m = pickMaster(a % 4);
        isReg = ((a / 4) % 2) == 1;
        wr = ((a / 8) % 2) == 1;
        wt = ((a / 16) % 2) == 1 ? LONG_WAIT + 1 : LONG_WAIT;
        access(m, isReg, wr, wt);
        if (expHit(e1, m1, r1, s1, MID_A, m, isReg, wr, wt)) exp1++;
        if (expHit(e2, m2, r2, s2, MID_B, m, isReg, wr, wt)) exp2++;
      end
      readReg(2'd2, rd); check($sformatf("R6 sweep %0d counter1", idx), rd, 32'(exp1));
      readReg(2'd3, rd); check($sformatf("R6 sweep %0d counter2", idx), rd, 32'(exp2));
    end

    // R4 master filter directed: counter 1 matches MID_A only
    writeReg(2'd1, selWord(MID_A, 4'h0, MID_B, 4'h0));
    writeReg(2'd0, cfgWord(4'd0, 1, 0, 4'd0, 0, 0));
    access(MID_A, 0, 0, 0);
    access(MID_B, 0, 0, 0);
    readReg(2'd2, rd); check("R4 master match", rd, 32'd1);
    readReg(2'd3, rd); check("R4 master off", rd, 32'd2);

    // R5 region filter directed: counter 1 registers only, counter 2 code 3
    writeReg(2'd1, selWord(MID_A, 4'h7, MID_B, 4'h3));
    writeReg(2'd0, cfgWord(4'd0, 0, 1, 4'd0, 0, 1));
    access(MID_A, 1, 0, 0);
    access(MID_A, 0, 0, 0);
    readReg(2'd2, rd); check("R5 region regs", rd, 32'd1);
    readReg(2'd3, rd); check("R5 region other code", rd, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule